// File: doc/BRIEF.md
# OTP Fuse Array Register Front End

This block places the control interface of a one-time-programmable fuse array on a simple 32-bit register bus. Firmware drives fifteen word-wide registers. Fourteen of them are plain control registers: fuse select, IO, address strobe, chip enable, clock, data in, data strobe, program, test control, test mode, test mode repeat, test read, trim and write enable. The fifteenth is a read-only data-out register that returns the fuse word picked by the select register.

The fuse array holds a fixed image after reset. Every word is all-ones except one serial-number word, and the word right after it holds the bitwise complement of that serial. The data-out path is gated. It returns the selected fuse word only when chip enable, data strobe and trim are all enabled. In every other case it returns 0x000000FF.

Requests use a valid/ready handshake. Each accepted request produces one registered response in the following cycle. That response is held until the requester takes it.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every control register reads 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: The registers sit at byte offsets 0x00 select, 0x04 IO, 0x08 address strobe, 0x0C chip enable, 0x10 clock, 0x14 data in, 0x18 data out, 0x1C data strobe, 0x20 program, 0x24 test control, 0x28 test mode, 0x2C test mode repeat, 0x30 test read, 0x34 trim and 0x38 write enable. Every register except data out reads back the last 32-bit value written to it.
- R3: A write to the select register stores only its low `FUSE_AW` bits, and the upper bits read back as 0. The fuse index is taken from these stored bits.
- R4: A read of data out returns the fuse word at the selected index when bit 0 of chip enable, data strobe and trim are all 1. Otherwise it returns 0x000000FF.
- R5: Fuse word `SERIAL_IDX` holds `SERIAL`, and word `SERIAL_IDX+1` holds `~SERIAL`. Every other fuse word reads 0xFFFFFFFF.
- R6: A write to data out changes no register, and later data-out reads are unaffected.
- R7: An access with address bits [1:0] not zero, or at a word offset of 0x3C or above, is unmapped. A read of it returns 0 and a write to it changes nothing.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 in the cycle after acceptance. While `rsp_valid` is 1 and `rsp_ready` is 0, the response and its data hold steady and `req_ready` is 0.
- R9: An accepted write returns a response whose `rsp_rdata` is 0.
- R10: Only bit 0 of the chip enable, data strobe and trim registers enables the read path. Other set bits do not open the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BUS_AW | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes) |

## Verification
The bench builds the block with `FUSE_AW` = 6, `SERIAL_IDX` = 62 and a non-symmetric `SERIAL` of 0xA5C30F1E. This makes the complement word land on the last index of the array. A select write of all-ones then reaches the top fuse word. A select value above 63 wraps through the mask onto the serial word. The small array also keeps the all-ones background and both serial words reachable with a handful of select writes. `BUS_AW` stays at 8, so both the unmapped gap above 0x38 and the last word offset 0xFC can be addressed.

// File: rtl/otpfa_pkg.sv
package otpfa_pkg;

  localparam int NREGS = 15;
  localparam int IDX_W = $clog2(NREGS);

  // Register word index; the byte offset is index * 4
  typedef enum logic [IDX_W-1:0] {
    RI_SEL   = 4'd0,
    RI_IO    = 4'd1,
    RI_ASTB  = 4'd2,
    RI_CE    = 4'd3,
    RI_CLK   = 4'd4,
    RI_DIN   = 4'd5,
    RI_DOUT  = 4'd6,
    RI_DSTB  = 4'd7,
    RI_PROG  = 4'd8,
    RI_TCTL  = 4'd9,
    RI_TMODE = 4'd10,
    RI_TMREP = 4'd11,
    RI_TREAD = 4'd12,
    RI_TRIM  = 4'd13,
    RI_WEN   = 4'd14
  } reg_idx_e;

  localparam logic [31:0] GATED_WORD = 32'h0000_00FF;

endpackage

// File: rtl/otpfa_ctrl_regs.sv
module otpfa_ctrl_regs
  import otpfa_pkg::*;
#(
  parameter int FUSE_AW = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [31:0]                  wr_data,
  output logic [NREGS-1:0][31:0]       regs_o
);

  localparam logic [31:0] SEL_MASK = 32'((64'd1 << FUSE_AW) - 64'd1);

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == int'(RI_DOUT)) begin : g_ro
      assign regs_o[i] = '0;
    end else begin : g_rw
      localparam logic [31:0] MASK = (i == int'(RI_SEL)) ? SEL_MASK : 32'hFFFF_FFFF;
      logic        en;
      logic [31:0] d;
      logic [31:0] q;

      always_comb begin
        en = wr_en && (wr_idx == IDX_W'(i));
        d  = wr_data & MASK;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (en) begin
          q <= d;
        end
      end

      assign regs_o[i] = q;
    end
  end

  // R2
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o));

endmodule

// File: rtl/otpfa_fuse_word.sv
module otpfa_fuse_word #(
  parameter int          FUSE_AW    = 12,
  parameter int          SERIAL_IDX = 'hFC,
  parameter logic [31:0] SERIAL     = 32'h0
) (
  input  logic [FUSE_AW-1:0] idx,
  output logic [31:0]        word
);

  localparam logic [FUSE_AW-1:0] SER_A = FUSE_AW'(SERIAL_IDX);
  localparam logic [FUSE_AW-1:0] SER_B = FUSE_AW'(SERIAL_IDX + 1);

  always_comb begin
    if (idx == SER_A) begin
      word = SERIAL;
    end else if (idx == SER_B) begin
      word = ~SERIAL;
    end else begin
      word = 32'hFFFF_FFFF;
    end
  end

endmodule

// File: rtl/otpfa_bus_resp.sv
module otpfa_bus_resp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  output logic        accept,
  input  logic [31:0] load_data,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata
);

  logic        valid_q, valid_d;
  logic [31:0] data_q;

  always_comb begin
    req_ready = !valid_q || rsp_ready;
    accept    = req_valid && req_ready;
    if (accept) begin
      valid_d = 1'b1;
    end else if (rsp_ready) begin
      valid_d = 1'b0;
    end else begin
      valid_d = valid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (accept) begin
      data_q <= load_data;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_rdata = data_q;

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R8
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otpfa_pkg::*;
#(
  parameter int          BUS_AW     = 8,
  parameter int          FUSE_AW    = 12,
  parameter int          SERIAL_IDX = 'hFC,
  parameter logic [31:0] SERIAL     = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BUS_AW-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata
);

  localparam int WORD_W = BUS_AW - 2;

  // Reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  // Address decode
  logic              aligned, hit, is_dout, accept, wr_en;
  logic [WORD_W-1:0] word;
  logic [IDX_W-1:0]  ridx;

  always_comb begin
    aligned = (req_addr[1:0] == 2'b00);
    word    = req_addr[BUS_AW-1:2];
    hit     = aligned && (word < WORD_W'(NREGS));
    ridx    = word[IDX_W-1:0];
    is_dout = hit && (ridx == RI_DOUT);
    wr_en   = accept && req_write && hit && !is_dout;
  end

  logic [NREGS-1:0][31:0] regs_q;

  otpfa_ctrl_regs #(.FUSE_AW(FUSE_AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .wr_idx  (ridx),
    .wr_data (req_wdata),
    .regs_o  (regs_q)
  );

  logic [FUSE_AW-1:0] fuse_idx;
  logic [31:0]        fuse_word;

  assign fuse_idx = regs_q[RI_SEL][FUSE_AW-1:0];

  otpfa_fuse_word #(
    .FUSE_AW    (FUSE_AW),
    .SERIAL_IDX (SERIAL_IDX),
    .SERIAL     (SERIAL)
  ) u_fuse (
    .idx  (fuse_idx),
    .word (fuse_word)
  );

  // Gated read path
  logic        gate_on;
  logic [31:0] rd_val;

  always_comb begin
    gate_on = regs_q[RI_CE][0] && regs_q[RI_DSTB][0] && regs_q[RI_TRIM][0];
    if (req_write || !hit) begin
      rd_val = '0;
    end else if (is_dout) begin
      rd_val = gate_on ? fuse_word : GATED_WORD;
    end else begin
      rd_val = regs_q[ridx];
    end
  end

  otpfa_bus_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .load_data (rd_val),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata)
  );

  // R4
  gated_read_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (accept && !req_write && is_dout && !gate_on) |=> (rsp_rdata == GATED_WORD));

  // R5
  serial_read_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (accept && !req_write && is_dout && gate_on &&
     (fuse_idx == FUSE_AW'(SERIAL_IDX))) |=> (rsp_rdata == SERIAL));

  // R6
  dout_wr_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (accept && req_write && is_dout) |=> $stable(regs_q));

  // R7
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (accept && !req_write && !hit) |=> (rsp_rdata == 32'h0));

  // R9
  wr_resp_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (accept && req_write) |=> (rsp_rdata == 32'h0));

endmodule

// File: tb/tb_otp_fuse_ctrl.sv
`timescale 1ns/1ps
module tb_otp_fuse_ctrl;

  localparam int          BUS_AW  = 8;
  localparam int          FAW     = 6;
  localparam int          SIDX    = 62;
  localparam logic [31:0] SER     = 32'hA5C3_0F1E;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write, rsp_ready;
  logic [BUS_AW-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic              req_ready, rsp_valid;
  logic [31:0]       rsp_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  otp_fuse_ctrl #(
    .BUS_AW(BUS_AW), .FUSE_AW(FAW), .SERIAL_IDX(SIDX), .SERIAL(SER)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  // {req tag[7:0], write, addr[7:0], wdata[31:0], expected rdata[31:0]}
  localparam int NV = 49;
  localparam logic [80:0] VEC [NV] = '{
    {8'd9,  1'b1, 8'h04, 32'h1111_0004, 32'h0},  // R9 writes acknowledged with 0
    {8'd9,  1'b1, 8'h08, 32'h2222_0008, 32'h0},
    {8'd9,  1'b1, 8'h10, 32'h3333_0010, 32'h0},
    {8'd9,  1'b1, 8'h14, 32'h4444_0014, 32'h0},
    {8'd9,  1'b1, 8'h20, 32'h5555_0020, 32'h0},
    {8'd9,  1'b1, 8'h24, 32'h6666_0024, 32'h0},
    {8'd9,  1'b1, 8'h28, 32'h7777_0028, 32'h0},
    {8'd9,  1'b1, 8'h2C, 32'h8888_002C, 32'h0},
    {8'd9,  1'b1, 8'h30, 32'h9999_0030, 32'h0},
    {8'd9,  1'b1, 8'h38, 32'hAAAA_0038, 32'h0},
    {8'd2,  1'b0, 8'h04, 32'h0, 32'h1111_0004},  // R2 readback
    {8'd2,  1'b0, 8'h08, 32'h0, 32'h2222_0008},
    {8'd2,  1'b0, 8'h10, 32'h0, 32'h3333_0010},
    {8'd2,  1'b0, 8'h14, 32'h0, 32'h4444_0014},
    {8'd2,  1'b0, 8'h20, 32'h0, 32'h5555_0020},
    {8'd2,  1'b0, 8'h24, 32'h0, 32'h6666_0024},
    {8'd2,  1'b0, 8'h28, 32'h0, 32'h7777_0028},
    {8'd2,  1'b0, 8'h2C, 32'h0, 32'h8888_002C},
    {8'd2,  1'b0, 8'h30, 32'h0, 32'h9999_0030},
    {8'd2,  1'b0, 8'h38, 32'h0, 32'hAAAA_0038},
    {8'd3,  1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},  // R3 select masked
    {8'd3,  1'b0, 8'h00, 32'h0, 32'h0000_003F},
    {8'd10, 1'b1, 8'h0C, 32'hFFFF_FFFE, 32'h0},  // R10 bit 0 of CE clear
    {8'd10, 1'b1, 8'h1C, 32'h0000_0001, 32'h0},
    {8'd10, 1'b1, 8'h34, 32'h0000_0001, 32'h0},
    {8'd10, 1'b0, 8'h18, 32'h0, 32'h0000_00FF},
    {8'd4,  1'b1, 8'h0C, 32'h0000_0001, 32'h0},  // R4 gate open
    {8'd2,  1'b0, 8'h0C, 32'h0, 32'h0000_0001},
    {8'd5,  1'b0, 8'h18, 32'h0, 32'h5A3C_F0E1},  // R5 complement word at 63
    {8'd3,  1'b1, 8'h00, 32'h0000_107E, 32'h0},
    {8'd3,  1'b0, 8'h00, 32'h0, 32'h0000_003E},
    {8'd5,  1'b0, 8'h18, 32'h0, 32'hA5C3_0F1E},  // R5 serial word at 62
    {8'd3,  1'b1, 8'h00, 32'h0000_0005, 32'h0},
    {8'd5,  1'b0, 8'h18, 32'h0, 32'hFFFF_FFFF},  // R5 background
    {8'd6,  1'b1, 8'h18, 32'h1234_5678, 32'h0},  // R6 write to data out
    {8'd6,  1'b0, 8'h18, 32'h0, 32'hFFFF_FFFF},
    {8'd6,  1'b0, 8'h00, 32'h0, 32'h0000_0005},
    {8'd7,  1'b1, 8'h3C, 32'h0000_DEAD, 32'h0},  // R7 unmapped
    {8'd7,  1'b0, 8'h3C, 32'h0, 32'h0},
    {8'd7,  1'b0, 8'h06, 32'h0, 32'h0},
    {8'd7,  1'b1, 8'h01, 32'h0000_BEEF, 32'h0},
    {8'd7,  1'b0, 8'h00, 32'h0, 32'h0000_0005},
    {8'd10, 1'b1, 8'h1C, 32'h0000_0002, 32'h0},  // R10 bit 0 of strobe clear
    {8'd10, 1'b0, 8'h18, 32'h0, 32'h0000_00FF},
    {8'd2,  1'b0, 8'h1C, 32'h0, 32'h0000_0002},
    {8'd4,  1'b1, 8'h1C, 32'h0000_0001, 32'h0},
    {8'd4,  1'b1, 8'h34, 32'hFFFF_FFFE, 32'h0},  // R4 trim bit 0 clear
    {8'd4,  1'b0, 8'h18, 32'h0, 32'h0000_00FF},
    {8'd7,  1'b0, 8'hFC, 32'h0, 32'h0}
  };

  task automatic check(input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] r, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid;
    r = rsp_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    logic        v;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rsp_ready = 1'b1;
    do_reset();

    // R1 reset state
    check(1, "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    check(1, "req_ready after reset", {31'b0, req_ready}, 32'h1);
    xfer(1'b0, 8'h0C, 32'h0, r, v);
    check(1, "chip enable reset", r, 32'h0);
    xfer(1'b0, 8'h00, 32'h0, r, v);
    check(1, "select reset", r, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][72], VEC[i][71:64], VEC[i][63:32], r, v);
      check(int'(VEC[i][80:73]), $sformatf("vector %0d valid", i), {31'b0, v}, 32'h1);
      check(int'(VEC[i][80:73]), $sformatf("vector %0d data", i), r, VEC[i][31:0]);
    end

    // R8 back-pressure: response held, request blocked
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h14; req_wdata = '0;
    @(negedge clk);
    req_write = 1'b1; req_wdata = 32'hCAFE_F00D;
    for (int k = 0; k < 3; k++) begin
      check(8, "stalled rsp_valid", {31'b0, rsp_valid}, 32'h1);
      check(8, "stalled rsp_rdata", rsp_rdata, 32'h4444_0014);
      check(8, "stalled req_ready", {31'b0, req_ready}, 32'h0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(9, "write after stall rdata", rsp_rdata, 32'h0);
    check(8, "write after stall valid", {31'b0, rsp_valid}, 32'h1);
    xfer(1'b0, 8'h14, 32'h0, r, v);
    check(8, "write taken after release", r, 32'hCAFE_F00D);

    // R1 reset in mid-run clears registers
    do_reset();
    check(1, "rsp_valid after second reset", {31'b0, rsp_valid}, 32'h0);
    xfer(1'b0, 8'h04, 32'h0, r, v);
    check(1, "IO reg after second reset", r, 32'h0);
    xfer(1'b0, 8'h18, 32'h0, r, v);
    check(4, "data out gated after reset", r, 32'h0000_00FF);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule